// File: doc/BRIEF.md
# Contactless Tag Response Frame Encoder

This block produces the load-switching signal that a passive 13.56 MHz tag uses to answer a reader. It runs on a clock at the carrier rate. Time is divided into slots of 256 carrier cycles. In each slot the single modulation line is either held low or toggled as a subcarrier at one thirty-second of the carrier frequency, which gives eight pulses per slot. A frame has three parts. It opens with a fixed eight-slot start marker, continues with the payload bytes, and closes with a fixed eight-slot end marker. Each payload bit takes two slots. A one is sent as a silent slot followed by a pulsed slot. A zero is sent as a pulsed slot followed by a silent slot. Within each byte the least significant bit goes out first.

A controller pulses a start strobe to begin a response. It then offers bytes on a valid/ready handshake and flags the final byte. The block asks for each byte just before that byte is needed, on a slot boundary. If no byte is offered at that moment, the frame closes with the end marker instead of stalling. A start strobe paired with a header-only flag sends the start marker by itself. A busy flag covers the whole response.

Top module: `tag_frame_encoder`

## Requirements
- R1: While reset is held, and in the first cycle after reset is released, `mod_o`, `busy_o` and `tx_ready_o` are all 0.
- R2: A slot lasts 256 cycles. The slot phase counter is 0 in the first cycle after reset is released and advances by one every cycle, modulo 256. In a pulsed slot, `mod_o` equals bit 4 of the phase: 16 cycles low, then 16 cycles high, repeated eight times. In a silent slot, `mod_o` is 0.
- R3: A start strobe seen while idle raises `busy_o` in the next cycle. The first start-marker slot begins in the first phase-0 cycle that lies at least two cycles after the strobe cycle.
- R4: The start marker is the slot sequence silent, silent, silent, pulsed, pulsed, pulsed, silent, pulsed.
- R5: Each payload byte takes 16 slots. Bit 0 goes first and bit 7 last. A bit of 1 is a silent slot then a pulsed slot. A bit of 0 is a pulsed slot then a silent slot.
- R6: After the byte that carried `tx_last_i` = 1, the end marker follows: pulsed, silent, pulsed, pulsed, pulsed, silent, silent, silent.
- R7: `tx_ready_o` is high for exactly one cycle, the phase-255 cycle of the final slot of the start marker or of a byte, whenever another byte is allowed. It is never high after the last-flagged byte. A byte is taken when `tx_valid_i` and `tx_ready_o` are both high.
- R8: If `tx_valid_i` is low in the cycle where `tx_ready_o` is high, no byte is taken and the end marker begins in the next slot.
- R9: A start strobe with `hdr_only_i` = 1 sends only the start marker. No byte is requested and no end marker is sent.
- R10: `busy_o` stays high until the final slot of the frame has ended and falls in the next cycle. `mod_o` is 0 whenever `busy_o` is 0.
- R11: A start strobe, with or without `hdr_only_i`, has no effect while a frame is in progress.
- R12: Asserting `rst` in the middle of a frame forces `mod_o` and `busy_o` to 0 from the next cycle on. After reset is released the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a response |
| hdr_only_i | input | 1 | Sampled with `start_i`: send the start marker only |
| tx_data_i | input | DATA_W | Payload byte offered |
| tx_valid_i | input | 1 | `tx_data_i` holds a byte |
| tx_last_i | input | 1 | The offered byte is the final one |
| tx_ready_o | output | 1 | The block takes a byte in this cycle |
| mod_o | output | 1 | Modulation enable (load switch) |
| busy_o | output | 1 | A response is in progress |

## Verification
The bench aims the start strobe at phases 254 and 255 of the slot grid. A design that miscounted the arming cycle would begin the frame one slot early or a whole slot late. Payloads of all zeros, all ones and mixed nibbles are compared against the waveform expected in every cycle. This exposes a reversed bit order, swapped half-bit slots or a subcarrier of the wrong phase. Byte offers are cut off after zero and after two bytes, which catches a design that stalls or takes a byte that was never offered. Other runs re-strike start mid-frame, request the start marker alone, and reset during a pulsed slot, to show that nothing leaks onto the load line afterward.

// File: rtl/tfe_pkg.sv
package tfe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_HDR,
    ST_BODY,
    ST_TRL
  } tfe_state_e;

  // Slot markers, emitted from the most significant slot downwards
  localparam int          MARK_SLOTS = 8;
  localparam logic [7:0]  HDR_MARK   = 8'h1D;
  localparam logic [7:0]  TRL_MARK   = 8'hB8;

  // Two-slot half-bit code of one data bit: 1 -> silent,pulsed ; 0 -> pulsed,silent
  function automatic logic [1:0] bit_pair(input logic b);
    return b ? 2'b01 : 2'b10;
  endfunction

endpackage

// File: rtl/tfe_slot_timer.sv
module tfe_slot_timer #(
  parameter int SLOT_LOG2 = 8,
  parameter int SUB_BIT   = 4
) (
  input  logic clk,
  input  logic rst,
  output logic slot_end,
  output logic slot_pre_end,
  output logic sub_next
);
  localparam logic [SLOT_LOG2-1:0] PH_LAST = '1;
  localparam logic [SLOT_LOG2-1:0] PH_PRE  = PH_LAST - 1'b1;

  logic [SLOT_LOG2-1:0] phase_q;
  logic [SLOT_LOG2-1:0] phase_n;

  assign phase_n = phase_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= phase_n;
  end

  assign slot_end     = (phase_q == PH_LAST);
  assign slot_pre_end = (phase_q == PH_PRE);
  assign sub_next     = phase_n[SUB_BIT];

  // R2: the pre-end cycle is always followed by the slot end
  p_pre_then_end_r2: assert property (@(posedge clk) disable iff (rst)
    slot_pre_end |=> slot_end);

endmodule

// File: rtl/tfe_slot_coder.sv
module tfe_slot_coder #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0]   data,
  output logic [2*DATA_W-1:0] slots
);
  import tfe_pkg::*;

  // Bit 0 lands in the most significant slot pair so it goes out first
  for (genvar g = 0; g < DATA_W; g++) begin : g_pair
    assign slots[2*DATA_W-1-2*g -: 2] = bit_pair(data[g]);
  end

endmodule

// File: rtl/tfe_frame_ctrl.sv
module tfe_frame_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                slot_end,
  input  logic                slot_pre_end,
  input  logic                sub_next,
  input  logic                start_i,
  input  logic                hdr_only_i,
  input  logic [2*DATA_W-1:0] byte_slots,
  input  logic                tx_valid_i,
  input  logic                tx_last_i,
  output logic                tx_ready_o,
  output logic                mod_o,
  output logic                busy_o
);
  import tfe_pkg::*;

  localparam int SRW = 2 * DATA_W;
  localparam int LW  = $clog2(SRW + 1);
  localparam logic [LW-1:0] LEFT_ONE  = LW'(1);
  localparam logic [LW-1:0] LEFT_MARK = LW'(MARK_SLOTS);
  localparam logic [LW-1:0] LEFT_BYTE = LW'(SRW);
  localparam logic [SRW-1:0] HDR_LOAD = {HDR_MARK, {(SRW-MARK_SLOTS){1'b0}}};
  localparam logic [SRW-1:0] TRL_LOAD = {TRL_MARK, {(SRW-MARK_SLOTS){1'b0}}};

  tfe_state_e     st_q, st_n;
  logic [SRW-1:0] sr_q, sr_n;
  logic [LW-1:0]  left_q, left_n;
  logic           hdr_q, hdr_n;
  logic           last_q, last_n;
  logic           ready_q, ready_n;
  logic           mod_q, mod_n;
  logic           busy_q;
  logic           take;
  logic           unit_done;
  logic           on_air_n;

  assign take      = tx_valid_i & ready_q;
  assign unit_done = (left_q == LEFT_ONE);

  always_comb begin
    st_n   = st_q;
    sr_n   = sr_q;
    left_n = left_q;
    hdr_n  = hdr_q;
    last_n = last_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_n   = ST_ARM;
          hdr_n  = hdr_only_i;
          last_n = 1'b0;
        end
      end
      ST_ARM: begin
        if (slot_end) begin
          st_n   = ST_HDR;
          sr_n   = HDR_LOAD;
          left_n = LEFT_MARK;
        end
      end
      ST_HDR, ST_BODY: begin
        if (slot_end) begin
          if (!unit_done) begin
            sr_n   = {sr_q[SRW-2:0], 1'b0};
            left_n = left_q - 1'b1;
          end else if (st_q == ST_HDR && hdr_q) begin
            st_n = ST_IDLE;
          end else if (take) begin
            st_n   = ST_BODY;
            sr_n   = byte_slots;
            left_n = LEFT_BYTE;
            last_n = tx_last_i;
          end else begin
            st_n   = ST_TRL;
            sr_n   = TRL_LOAD;
            left_n = LEFT_MARK;
          end
        end
      end
      ST_TRL: begin
        if (slot_end) begin
          if (!unit_done) begin
            sr_n   = {sr_q[SRW-2:0], 1'b0};
            left_n = left_q - 1'b1;
          end else begin
            st_n = ST_IDLE;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // Ready is raised for the last cycle of a unit when another byte may follow
  always_comb begin
    ready_n = slot_pre_end & unit_done &
              (((st_q == ST_HDR) & ~hdr_q) | ((st_q == ST_BODY) & ~last_q));
  end

  assign on_air_n = (st_n == ST_HDR) || (st_n == ST_BODY) || (st_n == ST_TRL);
  assign mod_n    = on_air_n & sr_n[SRW-1] & sub_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      sr_q    <= '0;
      left_q  <= '0;
      hdr_q   <= 1'b0;
      last_q  <= 1'b0;
      ready_q <= 1'b0;
      mod_q   <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      sr_q    <= sr_n;
      left_q  <= left_n;
      hdr_q   <= hdr_n;
      last_q  <= last_n;
      ready_q <= ready_n;
      mod_q   <= mod_n;
      busy_q  <= (st_n != ST_IDLE);
    end
  end

  assign tx_ready_o = ready_q;
  assign mod_o      = mod_q;
  assign busy_o     = busy_q;

  // R10: no load switching while idle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !mod_q);

  // R7: a byte is requested only in the final cycle of a slot
  p_ready_at_edge_r7: assert property (@(posedge clk) disable iff (rst)
    ready_q |-> slot_end);

  // R3: a strobe from idle raises busy next cycle
  p_start_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && start_i) |=> busy_q);

  // R11: mid-frame the sequencer moves only on slot edges, strobe or not
  p_frame_steady_r11: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !slot_end) |=> ($stable(st_q) && $stable(sr_q)));

  // R9: a header-only response never asks for a byte
  p_hdr_only_no_ready_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_q && hdr_q) |-> !ready_q);

  // R12: reset clears the outputs in the following cycle
  p_reset_clears_r12: assert property (@(posedge clk)
    rst |=> (!mod_q && !busy_q && !ready_q));

endmodule

// File: rtl/tag_frame_encoder.sv
module tag_frame_encoder #(
  parameter int SLOT_LOG2 = 8,
  parameter int SUB_BIT   = 4,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              hdr_only_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  input  logic              tx_last_i,
  output logic              tx_ready_o,
  output logic              mod_o,
  output logic              busy_o
);
  logic                slot_end;
  logic                slot_pre_end;
  logic                sub_next;
  logic [2*DATA_W-1:0] byte_slots;

  tfe_slot_timer #(
    .SLOT_LOG2 (SLOT_LOG2),
    .SUB_BIT   (SUB_BIT)
  ) i_timer (
    .clk          (clk),
    .rst          (rst),
    .slot_end     (slot_end),
    .slot_pre_end (slot_pre_end),
    .sub_next     (sub_next)
  );

  tfe_slot_coder #(
    .DATA_W (DATA_W)
  ) i_coder (
    .data  (tx_data_i),
    .slots (byte_slots)
  );

  tfe_frame_ctrl #(
    .DATA_W (DATA_W)
  ) i_ctrl (
    .clk          (clk),
    .rst          (rst),
    .slot_end     (slot_end),
    .slot_pre_end (slot_pre_end),
    .sub_next     (sub_next),
    .start_i      (start_i),
    .hdr_only_i   (hdr_only_i),
    .byte_slots   (byte_slots),
    .tx_valid_i   (tx_valid_i),
    .tx_last_i    (tx_last_i),
    .tx_ready_o   (tx_ready_o),
    .mod_o        (mod_o),
    .busy_o       (busy_o)
  );

endmodule

// File: tb/test_tag_frame_encoder.sv
`timescale 1ns/1ps
module test_tag_frame_encoder;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       hdr_only_i = 1'b0;
  logic [7:0] tx_data_i = 8'h00;
  logic       tx_valid_i = 1'b0;
  logic       tx_last_i = 1'b0;
  logic       tx_ready_o;
  logic       mod_o;
  logic       busy_o;

  int         n_run = 0;
  int         n_fail = 0;
  int         cyc = 0;
  logic [7:0] ph = 8'd0;
  logic [7:0] tx [0:7];

  always #2.5 clk = ~clk;

  tag_frame_encoder i_tag_frame_encoder (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .hdr_only_i (hdr_only_i),
    .tx_data_i  (tx_data_i),
    .tx_valid_i (tx_valid_i),
    .tx_last_i  (tx_last_i),
    .tx_ready_o (tx_ready_o),
    .mod_o      (mod_o),
    .busy_o     (busy_o)
  );

  // Slot phase model from R2: 0 in the first cycle out of reset
  always @(posedge clk) ph <= rst ? 8'd0 : ph + 8'd1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 180000) begin
      $display("FAIL watchdog R10: actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One frame, compared cycle by cycle against a model built from R2-R10
  task automatic run_frame(input string tag, input int n, input int supply,
                           input bit hdr, input int strobe_ph, input int restrike);
    bit   exp_s [0:255];
    int   len = 0;
    int   taken;
    int   idx = 0;
    bit   adv = 0;
    int   got = 0;
    int   j = 0;
    int   sj = -1;
    int   bad_m = 0, bad_b = 0, bad_r = 0;
    int   fm_j = -1, fb_j = -1, fr_j = -1;
    int   fm_a = 0, fm_e = 0, fb_a = 0, fb_e = 0, fr_a = 0, fr_e = 0;
    bit   em, eb, er;
    int   e, bi;
    logic [7:0] hdr_p = 8'h1D;
    logic [7:0] trl_p = 8'hB8;
    taken = hdr ? 0 : ((supply < n) ? supply : n);
    for (int s = 7; s >= 0; s--) begin exp_s[len] = hdr_p[s]; len++; end
    for (int i = 0; i < taken; i++)
      for (int b = 0; b < 8; b++) begin
        exp_s[len]   = !tx[i][b];
        exp_s[len+1] = tx[i][b];
        len += 2;
      end
    if (!hdr) for (int s = 7; s >= 0; s--) begin exp_s[len] = trl_p[s]; len++; end

    @(negedge clk);
    if (strobe_ph >= 0) while (ph != strobe_ph[7:0]) @(negedge clk);
    start_i    = 1'b1;
    hdr_only_i = hdr;
    tx_valid_i = !hdr && supply > 0 && n > 0;
    tx_data_i  = tx[0];
    tx_last_i  = (n == 1);

    while (sj < 0 || j < sj + len * 256 + 8) begin
      @(negedge clk);
      j++;
      if (j == 1) begin start_i = 1'b0; hdr_only_i = 1'b0; end
      if (restrike > 0 && j == restrike) begin start_i = 1'b1; hdr_only_i = 1'b1; end
      if (restrike > 0 && j == restrike + 1) begin start_i = 1'b0; hdr_only_i = 1'b0; end
      if (sj < 0 && j >= 2 && ph == 8'd0) sj = j;

      eb = (sj < 0) || (j < sj + len * 256);
      em = 1'b0;
      er = 1'b0;
      if (sj >= 0 && j < sj + len * 256)
        em = exp_s[(j - sj) / 256] && ((((j - sj) / 16) % 2) == 1);
      if (sj >= 0 && ((j - sj + 1) % 256) == 0) begin
        e = (j - sj + 1) / 256;
        if (!hdr && e == 8) er = 1'b1;
        else if (e > 8 && ((e - 8) % 16) == 0) begin
          bi = (e - 8) / 16 - 1;
          if (bi < taken && bi != n - 1) er = 1'b1;
        end
      end

      if (mod_o !== em) begin
        bad_m++;
        if (fm_j < 0) begin fm_j = j; fm_a = int'(mod_o); fm_e = int'(em); end
      end
      if (busy_o !== eb) begin
        bad_b++;
        if (fb_j < 0) begin fb_j = j; fb_a = int'(busy_o); fb_e = int'(eb); end
      end
      if (tx_ready_o !== er) begin
        bad_r++;
        if (fr_j < 0) begin fr_j = j; fr_a = int'(tx_ready_o); fr_e = int'(er); end
      end

      if (adv) begin
        adv = 1'b0;
        idx++;
        tx_valid_i = (idx < supply) && (idx < n);
        tx_data_i  = tx[idx % 8];
        tx_last_i  = (idx == n - 1);
      end
      if (tx_valid_i && tx_ready_o) begin adv = 1'b1; got++; end
    end
    tx_valid_i = 1'b0;
    tx_last_i  = 1'b0;

    check(bad_m == 0, {tag, " R2 R4 R5 R6"}, $sformatf("mod_o at cycle %0d", fm_j), fm_a, fm_e);
    check(bad_b == 0, {tag, " R3 R10"}, $sformatf("busy_o at cycle %0d", fb_j), fb_a, fb_e);
    check(bad_r == 0, {tag, " R7"}, $sformatf("tx_ready_o at cycle %0d", fr_j), fr_a, fr_e);
    check(got == taken, {tag, " R7 R8"}, "bytes taken", got, taken);
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    check(mod_o == 1'b0 && busy_o == 1'b0 && tx_ready_o == 1'b0, "R1", "outputs in reset",
          int'({mod_o, busy_o, tx_ready_o}), 0);
    rst = 1'b0;
    check(mod_o == 1'b0 && busy_o == 1'b0 && tx_ready_o == 1'b0, "R1", "outputs after release",
          int'({mod_o, busy_o, tx_ready_o}), 0);
  endtask

  task automatic t_single;
    tx[0] = 8'hA5;
    run_frame("single byte", 1, 1, 1'b0, -1, 0);
  endtask

  task automatic t_multi;
    tx[0] = 8'h00; tx[1] = 8'hFF; tx[2] = 8'h81; tx[3] = 8'h3C;
    run_frame("four bytes", 4, 4, 1'b0, -1, 0);
  endtask

  task automatic t_hdr_only;
    tx[0] = 8'h55;
    run_frame("R9 header only", 1, 1, 1'b1, -1, 0);
  endtask

  task automatic t_underrun;
    tx[0] = 8'h12; tx[1] = 8'hE7; tx[2] = 8'h99; tx[3] = 8'h44;
    run_frame("R8 underrun after two", 4, 2, 1'b0, -1, 0);
    run_frame("R8 underrun at once", 2, 0, 1'b0, -1, 0);
  endtask

  task automatic t_strobe_phase;
    run_frame("R3 strobe at phase 255", 1, 0, 1'b1, 255, 0);
    run_frame("R3 strobe at phase 254", 1, 0, 1'b1, 254, 0);
  endtask

  task automatic t_restrike;
    tx[0] = 8'h6B;
    run_frame("R11 restrike", 1, 1, 1'b0, -1, 700);
  endtask

  task automatic t_mid_reset;
    int k = 0;
    int hits = 0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (mod_o !== 1'b1 && k < 3000) begin @(negedge clk); k++; end
    check(mod_o == 1'b1, "R12", "pulse seen before reset", int'(mod_o), 1);
    rst = 1'b1;
    @(negedge clk);
    check(mod_o == 1'b0 && busy_o == 1'b0, "R12", "outputs after mid-frame reset",
          int'({mod_o, busy_o}), 0);
    rst = 1'b0;
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      if (mod_o !== 1'b0 || busy_o !== 1'b0) hits++;
    end
    check(hits == 0, "R12", "cycles active after reset release", hits, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) tx[i] = 8'h00;
    t_reset();
    t_single();
    t_multi();
    t_hdr_only();
    t_underrun();
    t_strobe_phase();
    t_restrike();
    t_mid_reset();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule